// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencing

This block produces all refresh activity for an asynchronous DRAM and sits beside the access controller that handles reads and writes. After reset it keeps the strobes idle for the power-up pause. It then runs a burst of initial refreshes before any access is granted. From then on it keeps a count of owed refreshes, adding one per refresh interval, and pays them off with column-before-row refresh cycles. While it runs one, it owns the row and column strobes. The refresh cycle needs no address.

Host traffic is arbitrated with a request/grant pair. A grant lasts until the request drops. Owed refreshes are served before the next grant. If the refreshes owed exceed a set count, a sticky overdue flag is raised.

A level request puts the device in self refresh, and the same request brings it out again. On the way in, one catch-up refresh runs, then the column strobe falls, then the row strobe falls and is held for at least the minimum self-refresh time. On the way out, the row strobe rises, the longer self-refresh precharge time passes, and one more catch-up refresh runs. All durations are given in nanoseconds and converted to clock cycles from the clock frequency, rounding up.

Top module: `ref_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are high, acc_gnt is low, busy is high and overdue is low.
- R2: After reset is released, ras_n and cas_n stay high for exactly PWRUP cycles, where PWRUP is ceil(PWRUP_NS*CLK_MHZ/1000). cas_n falls at the end of that count.
- R3: In every refresh cycle, cas_n falls T_CSR cycles before ras_n falls. cas_n stays low for as long as ras_n is low. A normal refresh holds ras_n low for T_RAS cycles, and both strobes rise together. Both strobes then stay high for T_RP cycles before another refresh begins.
- R4: Whenever ras_n or cas_n is low, ref_own is high and we_n is high.
- R5: The initial burst is exactly INIT_REFS back-to-back refreshes. busy stays high until the last one completes, and no grant is given before then.
- R6: After initialisation, with no host traffic, a refresh starts every REF_INT cycles.
- R7: Owed refreshes take priority over acc_req whenever the scheduler is idle. A grant lasts until acc_req drops. Every refresh owed at that point runs before the next grant.
- R8: overdue rises when more than MAX_LATE refreshes are owed, and it stays high until reset.
- R9: When sr_want is seen while idle, busy rises and one catch-up refresh runs. Then cas_n falls, and ras_n falls T_CSR cycles later.
- R10: In self refresh, ras_n stays low for at least SR_MIN cycles and for as long as sr_want stays high. It rises one cycle after sr_want is seen low past that minimum.
- R11: On leaving self refresh, both strobes stay high for T_RPS cycles. One catch-up refresh follows, then busy falls. The refresh interval restarts at that point.
- R12: acc_gnt is never high while ref_own or busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access controller wants the DRAM |
| sr_want | input | 1 | Level request to enter and hold self refresh |
| acc_gnt | output | 1 | Access controller may drive the DRAM |
| ref_own | output | 1 | Scheduler drives the strobes; data drivers must be off |
| ras_n | output | 1 | Row strobe during refresh |
| cas_n | output | 1 | Column strobe during refresh |
| we_n | output | 1 | Write enable, high during refresh |
| busy | output | 1 | Initialisation or self-refresh sequence in progress |
| overdue | output | 1 | Sticky flag: too many refreshes postponed |

## Verification
The bench first runs quiet stretches with no host traffic. These separate the free-running interval from any arbitration effect, and they pin the power-up count and the exact strobe widths.

Next come random host bursts from a seeded generator, each shorter than one interval. These show whether refreshes keep pace without ever overlapping a grant.

A single host hold spanning two intervals shows whether owed refreshes pile up and are all paid back before the next grant. A hold of six intervals separates the postponement limit from normal lag.

Finally, two self-refresh requests are run. One is dropped at once, which exposes the minimum hold. The other is held long, which shows that the request sets the exit time and that the long precharge and the exit refresh follow.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_HOST,
    ST_R_CSR,
    ST_R_RAS,
    ST_R_RP,
    ST_SR_CSR,
    ST_SR_HOLD,
    ST_SR_RPS
  } ref_state_e;

  typedef enum logic [1:0] {
    SR_NONE,
    SR_ENTER,
    SR_EXIT
  } sr_stage_e;

  // duration in ns -> whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int unsigned PERIOD = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int unsigned MAX_LATE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic sub,
  input  logic clr,
  output logic pending,
  output logic overdue
);
  localparam int unsigned DW = $clog2(MAX_LATE + 2) + 1;
  localparam logic [DW-1:0] SAT = '1;

  logic [DW-1:0] debt;
  logic          late_q;

  assign pending = (debt != '0);
  assign overdue = late_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                         debt <= '0;
    else if (add && !sub && debt != SAT)       debt <= debt + 1'b1;
    else if (sub && !add && debt != '0)        debt <= debt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) late_q <= 1'b0;
    else        late_q <= late_q | (debt > DW'(MAX_LATE));
  end
endmodule

// File: rtl/ref_phase_timer.sv
module ref_phase_timer #(
  parameter int unsigned TW      = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= TW'(RST_VAL);
    else if (load)  cnt <= val;
    else if (!zero) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned PWRUP_NS   = 200000,
  parameter int unsigned REF_INT_NS = 15600,
  parameter int unsigned SR_MIN_NS  = 100000,
  parameter int unsigned CSR_NS     = 5,
  parameter int unsigned RAS_NS     = 50,
  parameter int unsigned RP_NS      = 30,
  parameter int unsigned RPS_NS     = 90,
  parameter int unsigned INIT_REFS  = 8,
  parameter int unsigned MAX_LATE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic sr_want,
  output logic acc_gnt,
  output logic ref_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic overdue
);
  localparam int unsigned PWRUP_C   = ns_to_cyc(PWRUP_NS, CLK_MHZ);
  localparam int unsigned REF_INT_C = ns_to_cyc(REF_INT_NS, CLK_MHZ);
  localparam int unsigned SR_MIN_C  = ns_to_cyc(SR_MIN_NS, CLK_MHZ);
  localparam int unsigned T_CSR_C   = max2(ns_to_cyc(CSR_NS, CLK_MHZ), 1);
  localparam int unsigned T_RAS_C   = max2(ns_to_cyc(RAS_NS, CLK_MHZ), 1);
  localparam int unsigned T_RP_C    = max2(ns_to_cyc(RP_NS, CLK_MHZ), 1);
  localparam int unsigned T_RPS_C   = max2(ns_to_cyc(RPS_NS, CLK_MHZ), 1);
  localparam int unsigned LONGEST   = max2(max2(PWRUP_C, SR_MIN_C),
                                           max2(max2(T_CSR_C, T_RAS_C), max2(T_RP_C, T_RPS_C)));
  localparam int unsigned TW        = $clog2(LONGEST + 1);
  localparam int unsigned IW        = $clog2(INIT_REFS + 1);

  ref_state_e     state, nxt_state;
  sr_stage_e      sr_stage, sr_nxt;
  logic [IW-1:0]  init_left;
  logic           ld;
  logic [TW-1:0]  ld_val;
  logic           phase_zero;

  // named events for the checker
  logic in_pwrup, ref_done, sr_enter_ev, tick, run, pending;

  assign in_pwrup = (state == ST_PWRUP);
  assign run      = (init_left == '0) && (sr_stage == SR_NONE);

  ref_phase_timer #(.TW(TW), .RST_VAL(PWRUP_C - 1)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ld), .val(ld_val), .zero(phase_zero)
  );

  ref_tick_gen #(.PERIOD(REF_INT_C)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ref_debt_ctr #(.MAX_LATE(MAX_LATE)) u_debt (
    .clk(clk), .rst_n(rst_n), .add(tick),
    .sub(ref_done && (init_left == '0)), .clr(sr_enter_ev),
    .pending(pending), .overdue(overdue)
  );

  always_comb begin
    nxt_state   = state;
    sr_nxt      = sr_stage;
    ld          = 1'b0;
    ld_val      = '0;
    ref_done    = 1'b0;
    sr_enter_ev = 1'b0;
    case (state)
      ST_PWRUP: if (phase_zero) begin
        nxt_state = ST_R_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
      end
      ST_IDLE: begin
        if (sr_want) begin
          sr_nxt = SR_ENTER; nxt_state = ST_R_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
        end else if (pending) begin
          nxt_state = ST_R_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
        end else if (acc_req) begin
          nxt_state = ST_HOST;
        end
      end
      ST_HOST: if (!acc_req) nxt_state = ST_IDLE;
      ST_R_CSR: if (phase_zero) begin
        nxt_state = ST_R_RAS; ld = 1'b1; ld_val = TW'(T_RAS_C - 1);
      end
      ST_R_RAS: if (phase_zero) begin
        nxt_state = ST_R_RP; ld = 1'b1; ld_val = TW'(T_RP_C - 1);
      end
      ST_R_RP: if (phase_zero) begin
        ref_done = 1'b1;
        if (init_left > IW'(1)) begin
          nxt_state = ST_R_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
        end else if (sr_stage == SR_ENTER) begin
          sr_enter_ev = 1'b1;
          nxt_state = ST_SR_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
        end else begin
          nxt_state = ST_IDLE; sr_nxt = SR_NONE;
        end
      end
      ST_SR_CSR: if (phase_zero) begin
        nxt_state = ST_SR_HOLD; ld = 1'b1; ld_val = TW'(SR_MIN_C - 1);
      end
      ST_SR_HOLD: if (phase_zero && !sr_want) begin
        nxt_state = ST_SR_RPS; ld = 1'b1; ld_val = TW'(T_RPS_C - 1);
      end
      ST_SR_RPS: if (phase_zero) begin
        sr_nxt = SR_EXIT; nxt_state = ST_R_CSR; ld = 1'b1; ld_val = TW'(T_CSR_C - 1);
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PWRUP;
      sr_stage  <= SR_NONE;
      init_left <= IW'(INIT_REFS);
    end else begin
      state    <= nxt_state;
      sr_stage <= sr_nxt;
      if (ref_done && init_left != '0) init_left <= init_left - 1'b1;
    end
  end

  assign ras_n   = !(state == ST_R_RAS || state == ST_SR_HOLD);
  assign cas_n   = !(state inside {ST_R_CSR, ST_R_RAS, ST_SR_CSR, ST_SR_HOLD});
  assign ref_own = state inside {ST_R_CSR, ST_R_RAS, ST_R_RP, ST_SR_CSR, ST_SR_HOLD, ST_SR_RPS};
  assign we_n    = 1'b1;
  assign acc_gnt = (state == ST_HOST);
  assign busy    = in_pwrup || (init_left != '0) || (sr_stage != SR_NONE);

endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int unsigned T_RAS_C  = 13,
  parameter int unsigned SR_MIN_C = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic ref_own,
  input logic acc_gnt,
  input logic busy,
  input logic overdue,
  input logic in_pwrup
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) low_cnt <= '0;
    else                 low_cnt <= low_cnt + 1;
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_pwrup |-> (ras_n && cas_n)); // R2
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)); // R3
  AST_CAS_COVERS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt == T_RAS_C || low_cnt >= SR_MIN_C)); // R10
  AST_OWN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_own); // R4
  AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |=> overdue); // R8
  AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (!ref_own && !busy)); // R12
endmodule

bind ref_sched ref_sched_chk #(.T_RAS_C(T_RAS_C), .SR_MIN_C(SR_MIN_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .ref_own(ref_own),
  .acc_gnt(acc_gnt), .busy(busy), .overdue(overdue), .in_pwrup(in_pwrup)
);

// File: tb/ref_sched_tb.sv
`timescale 1ns/1ps
module ref_sched_tb;
  localparam int MHZ = 250, PW_NS = 2000, RI_NS = 2000, SRM_NS = 1200;
  localparam int INITN = 8, LATE = 4;

  function automatic int cyc_of(int ns);
    int p = ns * MHZ;
    return p / 1000 + ((p % 1000) != 0 ? 1 : 0);
  endfunction

  localparam int PW_C = cyc_of(PW_NS), RI_C = cyc_of(RI_NS), SRM_C = cyc_of(SRM_NS);
  localparam int CSR_C = cyc_of(5), RAS_C = cyc_of(50), RP_C = cyc_of(30), RPS_C = cyc_of(90);

  logic clk = 0, rst_n = 0, acc_req = 0, sr_want = 0;
  logic acc_gnt, ref_own, ras_n, cas_n, we_n, busy, overdue;

  ref_sched #(.CLK_MHZ(MHZ), .PWRUP_NS(PW_NS), .REF_INT_NS(RI_NS), .SR_MIN_NS(SRM_NS),
              .INIT_REFS(INITN), .MAX_LATE(LATE)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sr_want(sr_want), .acc_gnt(acc_gnt),
    .ref_own(ref_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy), .overdue(overdue));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor, sampled at negedge
  bit mon_on = 0;
  int cyc = 0, np = 0, hi_run = 0, lead = 0, rlow = 0, viol = 0;
  logic pc = 1, pr = 1;
  int pstart[0:1023], pgap[0:1023], plead[0:1023], prlen[0:1023], pbusy[0:1023];

  always @(negedge clk) if (mon_on) begin
    cyc++;
    if (!cas_n && pc) begin
      pstart[np] = cyc; pgap[np] = hi_run; pbusy[np] = busy; np++;
    end
    if (np > 0 && !ras_n && pr) plead[np-1] = lead;
    if (np > 0 && ras_n && !pr) prlen[np-1] = rlow;
    hi_run = (ras_n && cas_n) ? hi_run + 1 : 0;
    lead   = (!cas_n && ras_n) ? lead + 1 : 0;
    rlow   = !ras_n ? rlow + 1 : 0;
    if ((!ras_n || !cas_n) && (!we_n || !ref_own || acc_gnt)) viol++;
    pc = cas_n; pr = ras_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, a, b, s, t_rel, got, np0, cyc0, c, d;
    void'($urandom(32'h00c0ffee));
    acc_req = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 acc_gnt", acc_gnt, 0); chk("R1 busy", busy, 1); chk("R1 overdue", overdue, 0);
    rst_n = 1; mon_on = 1;
    // R2 power-up pause
    n = 0;
    do begin @(negedge clk); n++; end while (cas_n);
    chk("R2 pause cycles", n, PW_C);
    // R5 initial burst
    while (busy) begin
      if (acc_gnt) chk("R5 grant during init", 1, 0);
      @(negedge clk);
    end
    chk("R5 init refresh count", np, INITN);
    chk("R12 gnt at busy fall", acc_gnt, 0);
    for (int i = 0; i < INITN; i++) begin
      chk("R3 lead", plead[i], CSR_C);
      chk("R3 ras width", prlen[i], RAS_C);
      if (i > 0) chk("R3 precharge", pgap[i], RP_C);
    end
    @(negedge clk);
    chk("R7 grant after init", acc_gnt, 1);
    acc_req = 0;
    // R6 free-running interval
    while (np < INITN + 3) @(negedge clk);
    chk("R6 interval", pstart[INITN+2] - pstart[INITN+1], RI_C);
    // random host bursts
    while (!ras_n || !cas_n) @(negedge clk);
    np0 = np; cyc0 = cyc;
    for (int it = 0; it < 20; it++) begin
      repeat ($urandom_range(0, 300)) @(negedge clk);
      acc_req = 1;
      repeat ($urandom_range(1, 200)) @(negedge clk);
      acc_req = 0;
    end
    repeat (300) @(negedge clk);
    n = (cyc - cyc0) / RI_C;
    got = np - np0;
    chk("R6 refreshes kept pace", (got >= n - 1 && got <= n + 1) ? 1 : 0, 1);
    for (int i = np0; i < np; i++) begin
      chk("R3 lead random", plead[i], CSR_C);
      chk("R3 width random", prlen[i], RAS_C);
    end
    // R7 priority after a long grant
    n = np;
    while (np == n) @(negedge clk);
    while (!ras_n) @(negedge clk);
    s = pstart[np-1];
    acc_req = 1;
    n = np;
    repeat (1200) @(negedge clk);
    chk("R7 no refresh during grant", np - n, 0);
    chk("R8 no overdue at two owed", overdue, 0);
    t_rel = cyc;
    acc_req = 0; @(negedge clk); acc_req = 1;
    n = np;
    while (!acc_gnt) @(negedge clk);
    chk("R7 owed refreshes before regrant", np - n, (t_rel - s) / RI_C);
    chk("R12 strobes idle at grant", ras_n & cas_n, 1);
    // R9 short self refresh
    acc_req = 0; sr_want = 1; a = np;
    while (!busy) @(negedge clk);
    sr_want = 0;
    while (busy) @(negedge clk);
    chk("R9 pulse count", np - a, 3);
    chk("R9 catch-up width", prlen[a], RAS_C);
    chk("R9 gap before self refresh", pgap[a+1], RP_C);
    chk("R9 cas lead", plead[a+1], CSR_C);
    chk("R9 busy in self refresh", pbusy[a+1], 1);
    chk("R10 minimum hold", prlen[a+1], SRM_C);
    chk("R11 exit precharge", pgap[a+2], RPS_C);
    chk("R11 exit refresh width", prlen[a+2], RAS_C);
    // R10 long self refresh
    sr_want = 1; b = np;
    while (np < b + 2) @(negedge clk);
    repeat (CSR_C + SRM_C + 100) @(negedge clk);
    chk("R10 held while requested", ras_n, 0);
    sr_want = 0;
    @(negedge clk);
    chk("R10 exit next cycle", ras_n, 1);
    while (busy) @(negedge clk);
    c = cyc;
    chk("R11 exit precharge long", pgap[b+2], RPS_C);
    while (np < b + 4) @(negedge clk);
    d = pstart[b+3] - c;
    chk("R11 interval restart", (d >= RI_C - 2 && d <= RI_C + 2) ? 1 : 0, 1);
    // R8 overdue
    acc_req = 1;
    repeat (6 * RI_C + 20) @(negedge clk);
    chk("R8 overdue raised", overdue, 1);
    acc_req = 0;
    repeat (200) @(negedge clk);
    chk("R8 overdue sticky", overdue, 1);
    chk("R4 owner and write enable during strobes", viol, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule